// File: doc/BRIEF.md
# Level-Qualified Overflow Capture Timer

This block is an 8-bit up-counter with a single 8-bit control and status register. The counter advances on a count enable taken from a free-running prescaler. Two register bits pick one of four division ratios. The block also watches an asynchronous capture pin. It brings that pin into the clock domain through a synchronizer, then uses it three ways: its level, its edges, and a capture-edge interrupt.

When the counter wraps from 0xFF to 0x00, the block records the wrap in one of two sticky flags. Which flag it uses depends on the synchronized capture level at that moment. In interval operation, selected by a mode input, the wrap always lands in the low-level flag. Capture edges can optionally clear the counter, and interval operation disables that clearing.

Software can never set a flag. To remove a flag, software must first observe it as 1 through a register read and then write 0 to it. An overflow interrupt combines the two flags with an enable bit. A second interrupt pulses on the capture edge polarity chosen in the register.

Top module: `ovf_capture_timer`

## Requirements
- R1: After reset the register reads 0x00, the counter reads 0x00, and both interrupt outputs are low.
- R2: Clock select (register bits 1:0) values 00, 01, 10 and 11 make the counter advance by one every 64, 32, 16 and 4 clock cycles respectively.
- R3: A wrap from 0xFF to 0x00 sets bit 7 (high flag), and only bit 7, when the synchronized capture level is 1 and interval mode is off.
- R4: A wrap sets bit 6 (low flag), and only bit 6, when the synchronized capture level is 0, or at any capture level when interval mode is on.
- R5: Writing 1 to bit 7 or bit 6 never sets that flag. Bits 5:0 take the written value and read back unchanged.
- R6: A write of 0 to a flag bit clears that flag only if a register read was made while the flag was 1 since the flag was last cleared. Without that read the flag stays 1.
- R7: If a wrap that sets a flag coincides with a valid clearing write to that flag, the flag stays 1.
- R8: The overflow interrupt is high exactly when bit 5 (enable) is 1 and at least one of bits 7 and 6 is 1.
- R9: Clear select (bits 3:2) value 00 never clears the counter, 01 clears it on a falling capture edge, 10 on a rising edge, and 11 on either edge. The clear takes effect at the third rising clock edge after the pin changes. In interval mode, edges never clear the counter.
- R10: The capture-edge interrupt is a one-cycle pulse. It is high during the cycle after the second rising clock edge following a pin change. It responds to rising edges when bit 4 is 1 and to falling edges when bit 4 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| interval_mode_i | input | 1 | 1 selects interval operation |
| cap_i | input | 1 | Asynchronous capture pin |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_rd_i | input | 1 | Register read strobe, arms flags seen as 1 |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Current register contents |
| count_o | output | 8 | Current counter value |
| ovf_irq_o | output | 1 | Overflow interrupt |
| cap_irq_o | output | 1 | Capture-edge interrupt pulse |

## Verification
The embedded assertions check, on every cycle, several properties of the block. A flag only rises in a cycle after a wrap with the matching level and mode. A flag only falls after an armed zero-write. A wrap with a simultaneous clear still leaves the flag set. The counter only ever steps by one or drops to zero. A counter clear or wrap leaves zero behind it. Enables and edge pulses never last two cycles.

The exact division ratios need the directed scenarios, as do the three-edge clear latency, the polarity choice of the edge interrupt, and the behaviour of each clear-select code against each edge direction. The scenarios also cover the read-then-write clearing protocol as seen from the register port, and the deliberate alignment of a clearing write with a wrap.

// File: rtl/otm_pkg.sv
package otm_pkg;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_FALL = 2'b01,
        CLR_RISE = 2'b10,
        CLR_BOTH = 2'b11
    } clr_sel_e;

    // Packed so that the first member lands in bit 7.
    typedef struct packed {
        logic       flag_hi;   // bit 7
        logic       flag_lo;   // bit 6
        logic       ovf_ie;    // bit 5
        logic       edge_pol;  // bit 4
        logic [1:0] clr_sel;   // bits 3:2
        logic [1:0] clk_sel;   // bits 1:0
    } ctrl_t;

endpackage

// File: rtl/otm_prescaler.sv
module otm_prescaler #(
    parameter int DIV_0 = 64,
    parameter int DIV_1 = 32,
    parameter int DIV_2 = 16,
    parameter int DIV_3 = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_sel_i,
    output logic       tick_o
);
    localparam int MAX_01  = (DIV_0 > DIV_1) ? DIV_0 : DIV_1;
    localparam int MAX_23  = (DIV_2 > DIV_3) ? DIV_2 : DIV_3;
    localparam int DIV_MAX = (MAX_01 > MAX_23) ? MAX_01 : MAX_23;
    localparam int PRE_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
    localparam logic [PRE_W-1:0] MASK_0 = PRE_W'(DIV_0 - 1);
    localparam logic [PRE_W-1:0] MASK_1 = PRE_W'(DIV_1 - 1);
    localparam logic [PRE_W-1:0] MASK_2 = PRE_W'(DIV_2 - 1);
    localparam logic [PRE_W-1:0] MASK_3 = PRE_W'(DIV_3 - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + PRE_W'(1);
        case (clk_sel_i)
            2'd0:    mask = MASK_0;
            2'd1:    mask = MASK_1;
            2'd2:    mask = MASK_2;
            default: mask = MASK_3;
        endcase
        tick_o = ((st_q.pre & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: with an unchanged select, two enables are never adjacent
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && clk_sel_i == 2'd3) |=> !(tick_o && clk_sel_i == 2'd3))
        else $error("enable held two cycles");

endmodule

// File: rtl/otm_capture_sync.sv
module otm_capture_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], cap_i};
        st_d.prev = st_q.sh[STAGES-1];
        level_o   = st_q.sh[STAGES-1];
        rise_o    = st_q.sh[STAGES-1] & ~st_q.prev;
        fall_o    = ~st_q.sh[STAGES-1] & st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: edge indications last one cycle
    a_r10_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o) else $error("rise held");
    a_r10_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o) else $error("fall held");

endmodule

// File: rtl/otm_counter.sv
module otm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        ovf_o = tick_i & ~clr_i & (&st_q.cnt);
        if (clr_i)       st_d.cnt = '0;
        else if (tick_i) st_d.cnt = st_q.cnt + CNT_W'(1);
        cnt_o = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a wrap leaves zero
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_o == '0)) else $error("wrap not zero");
    // R9: a clear leaves zero
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0)) else $error("clear not zero");
    // R2: the counter only steps by one or falls to zero
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_o) |-> ((cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1))) || (cnt_o == '0)))
        else $error("counter jumped");

endmodule

// File: rtl/otm_ctrl_reg.sv
module otm_ctrl_reg
    import otm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic       rd_i,
    input  logic [7:0] wdata_i,
    input  logic       ovf_i,
    input  logic       cap_lvl_i,
    input  logic       interval_i,
    output logic [7:0] rdata_o,
    output ctrl_t      ctrl_o,
    output logic       ovf_irq_o
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  arm_hi;
        logic  arm_lo;
    } reg_st_t;

    reg_st_t st_d, st_q;
    ctrl_t   wr_view;
    logic    set_hi, set_lo, clr_hi, clr_lo;

    always_comb begin
        wr_view = ctrl_t'(wdata_i);
        set_hi  = ovf_i & cap_lvl_i & ~interval_i;
        set_lo  = ovf_i & (~cap_lvl_i | interval_i);
        clr_hi  = wr_i & ~wr_view.flag_hi & st_q.arm_hi;
        clr_lo  = wr_i & ~wr_view.flag_lo & st_q.arm_lo;

        st_d = st_q;
        if (wr_i) begin
            st_d.ctrl.ovf_ie   = wr_view.ovf_ie;
            st_d.ctrl.edge_pol = wr_view.edge_pol;
            st_d.ctrl.clr_sel  = wr_view.clr_sel;
            st_d.ctrl.clk_sel  = wr_view.clk_sel;
        end

        // flag updates: hardware set wins over an armed clear
        if (set_hi)      st_d.ctrl.flag_hi = 1'b1;
        else if (clr_hi) st_d.ctrl.flag_hi = 1'b0;
        if (set_lo)      st_d.ctrl.flag_lo = 1'b1;
        else if (clr_lo) st_d.ctrl.flag_lo = 1'b0;

        // arming follows a read that observed the flag at 1
        if (clr_hi && !set_hi)             st_d.arm_hi = 1'b0;
        else if (rd_i && st_q.ctrl.flag_hi) st_d.arm_hi = 1'b1;
        if (clr_lo && !set_lo)             st_d.arm_lo = 1'b0;
        else if (rd_i && st_q.ctrl.flag_lo) st_d.arm_lo = 1'b1;

        rdata_o   = st_q.ctrl;
        ctrl_o    = st_q.ctrl;
        ovf_irq_o = st_q.ctrl.ovf_ie & (st_q.ctrl.flag_hi | st_q.ctrl.flag_lo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3/R5: the high flag only rises after a high-level wrap
    a_r5_hi_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdata_o[7]) |-> $past(ovf_i && cap_lvl_i && !interval_i))
        else $error("high flag rose without wrap");
    // R4/R5: the low flag only rises after a low-level or interval wrap
    a_r5_lo_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdata_o[6]) |-> $past(ovf_i && (!cap_lvl_i || interval_i)))
        else $error("low flag rose without wrap");
    // R6: a flag only falls after an armed zero write
    a_r6_hi_fall_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdata_o[7]) |-> $past(wr_i && !wdata_i[7] && st_q.arm_hi))
        else $error("high flag fell unarmed");
    a_r6_lo_fall_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdata_o[6]) |-> $past(wr_i && !wdata_i[6] && st_q.arm_lo))
        else $error("low flag fell unarmed");
    // R7: a wrap always leaves its flag set
    a_r7_hi_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && cap_lvl_i && !interval_i) |=> rdata_o[7])
        else $error("high flag lost to clear");
    a_r7_lo_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && (!cap_lvl_i || interval_i)) |=> rdata_o[6])
        else $error("low flag lost to clear");

endmodule

// File: rtl/ovf_capture_timer.sv
module ovf_capture_timer
    import otm_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_0       = 64,
    parameter int DIV_1       = 32,
    parameter int DIV_2       = 16,
    parameter int DIV_3       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             interval_mode_i,
    input  logic             cap_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [7:0]       reg_wdata_i,
    output logic [7:0]       reg_rdata_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_irq_o,
    output logic             cap_irq_o
);
    ctrl_t    ctrl;
    clr_sel_e clr_sel;
    logic     tick, cap_lvl, cap_rise, cap_fall, edge_clr, ovf;

    otm_prescaler #(
        .DIV_0(DIV_0), .DIV_1(DIV_1), .DIV_2(DIV_2), .DIV_3(DIV_3)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel_i (ctrl.clk_sel),
        .tick_o    (tick)
    );

    otm_capture_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap_i),
        .level_o (cap_lvl),
        .rise_o  (cap_rise),
        .fall_o  (cap_fall)
    );

    always_comb begin
        clr_sel = clr_sel_e'(ctrl.clr_sel);
        case (clr_sel)
            CLR_FALL: edge_clr = cap_fall;
            CLR_RISE: edge_clr = cap_rise;
            CLR_BOTH: edge_clr = cap_rise | cap_fall;
            default:  edge_clr = 1'b0;
        endcase
        if (interval_mode_i) edge_clr = 1'b0;
        cap_irq_o = ctrl.edge_pol ? cap_rise : cap_fall;
    end

    otm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .clr_i  (edge_clr),
        .cnt_o  (count_o),
        .ovf_o  (ovf)
    );

    otm_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .rd_i       (reg_rd_i),
        .wdata_i    (reg_wdata_i),
        .ovf_i      (ovf),
        .cap_lvl_i  (cap_lvl),
        .interval_i (interval_mode_i),
        .rdata_o    (reg_rdata_o),
        .ctrl_o     (ctrl),
        .ovf_irq_o  (ovf_irq_o)
    );

    // R10: the capture interrupt is a single-cycle pulse
    a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq_o |=> !cap_irq_o) else $error("capture irq held");
    // R9: interval mode never lets an edge clear the counter
    a_r9_interval_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_mode_i && count_o != '1 && count_o != '0) |=> (count_o != '0))
        else $error("interval clear");

endmodule

// File: tb/ovf_capture_timer_tb.sv
module ovf_capture_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       interval_mode_i = 1'b0;
    logic       cap_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic       reg_rd_i = 1'b0;
    logic [7:0] reg_wdata_i = 8'h00;
    logic [7:0] reg_rdata_o;
    logic [7:0] count_o;
    logic       ovf_irq_o;
    logic       cap_irq_o;

    int checks = 0;
    int fails  = 0;

    always #2ns clk = ~clk;

    ovf_capture_timer dut_i (
        .clk(clk), .rst_n(rst_n), .interval_mode_i(interval_mode_i), .cap_i(cap_i),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .count_o(count_o),
        .ovf_irq_o(ovf_irq_o), .cap_irq_o(cap_irq_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk); reg_wr_i = 1'b1; reg_wdata_i = v;
        @(negedge clk); reg_wr_i = 1'b0;
    endtask

    task automatic read_reg(output logic [7:0] v);
        @(negedge clk); v = reg_rdata_o; reg_rd_i = 1'b1;
        @(negedge clk); reg_rd_i = 1'b0;
    endtask

    // returns at the falling edge right after the counter has moved
    task automatic wait_tick();
        logic [7:0] c;
        c = count_o;
        while (count_o == c) @(negedge clk);
    endtask

    task automatic run_to_wrap();
        while (count_o != 8'hFF) @(negedge clk);
        wait_tick();
    endtask

    task automatic clear_flags(input logic [7:0] ctl);
        logic [7:0] v;
        read_reg(v);
        write_reg(ctl & 8'h3F);
    endtask

    task automatic t_reset();
        chk(reg_rdata_o == 8'h00, "R1", "register after reset", reg_rdata_o, 0);
        chk(count_o == 8'h00, "R1", "counter after reset", count_o, 0);
        chk(!ovf_irq_o && !cap_irq_o, "R1", "irqs after reset",
            {ovf_irq_o, cap_irq_o}, 0);
    endtask

    task automatic t_rates();
        int divs[4] = '{64, 32, 16, 4};
        for (int s = 0; s < 4; s++) begin
            int n;
            logic [7:0] c;
            write_reg(8'(s));
            wait_tick();
            c = count_o;
            n = 0;
            do begin @(negedge clk); n++; end while (count_o == c);
            chk(n == divs[s], "R2", $sformatf("period for select %0d", s), n, divs[s]);
        end
        clear_flags(8'h03);
    endtask

    task automatic t_overflow_high();
        logic [7:0] v;
        cap_i = 1'b1;
        repeat (4) @(negedge clk);
        clear_flags(8'h03);
        run_to_wrap();
        chk(reg_rdata_o[7:6] == 2'b10, "R3", "flags after high wrap", reg_rdata_o[7:6], 2);
        chk(!ovf_irq_o, "R8", "irq with enable off", ovf_irq_o, 0);
        write_reg(8'h23);
        chk(reg_rdata_o[7] == 1'b1, "R6", "zero write without read", reg_rdata_o[7], 1);
        chk(ovf_irq_o == 1'b1, "R8", "irq with enable on", ovf_irq_o, 1);
        read_reg(v);
        write_reg(8'h23);
        chk(reg_rdata_o[7] == 1'b0, "R6", "zero write after read", reg_rdata_o[7], 0);
        chk(!ovf_irq_o, "R8", "irq after clear", ovf_irq_o, 0);
        write_reg(8'h03);
    endtask

    task automatic t_overflow_low();
        cap_i = 1'b0;
        repeat (4) @(negedge clk);
        clear_flags(8'h03);
        run_to_wrap();
        chk(reg_rdata_o[7:6] == 2'b01, "R4", "flags after low wrap", reg_rdata_o[7:6], 1);
        clear_flags(8'h03);
        chk(reg_rdata_o[7:6] == 2'b00, "R6", "low flag cleared", reg_rdata_o[7:6], 0);
        interval_mode_i = 1'b1;
        cap_i = 1'b1;
        repeat (4) @(negedge clk);
        run_to_wrap();
        chk(reg_rdata_o[7:6] == 2'b01, "R4", "flags after interval wrap",
            reg_rdata_o[7:6], 1);
        clear_flags(8'h03);
        interval_mode_i = 1'b0;
        cap_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_sw_write();
        write_reg(8'hFF);
        chk(reg_rdata_o == 8'h3F, "R5", "write all ones", reg_rdata_o, 8'h3F);
        write_reg(8'hD5);
        chk(reg_rdata_o == 8'h15, "R5", "write with flag bits", reg_rdata_o, 8'h15);
        chk(!ovf_irq_o, "R5", "no irq from written flag bits", ovf_irq_o, 0);
        write_reg(8'h03);
    endtask

    task automatic t_set_priority();
        logic [7:0] v;
        cap_i = 1'b1;
        repeat (4) @(negedge clk);
        run_to_wrap();
        read_reg(v);
        while (count_o != 8'hFE) @(negedge clk);
        wait_tick();
        repeat (2) @(negedge clk);
        write_reg(8'h03);
        chk(count_o == 8'h00, "R7", "write aligned with wrap", count_o, 0);
        chk(reg_rdata_o[7] == 1'b1, "R7", "flag kept on collision", reg_rdata_o[7], 1);
        clear_flags(8'h03);
        cap_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic edge_try(input logic newval, input bit exp_clr, input string what);
        logic [7:0] c0;
        wait_tick();
        while (count_o < 8'd2 || count_o > 8'hF0) @(negedge clk);
        c0 = count_o;
        cap_i = newval;
        repeat (3) @(posedge clk);
        #1ns;
        if (exp_clr)
            chk(count_o == 8'h00, "R9", what, count_o, 0);
        else
            chk((8'(count_o - c0) <= 8'd1), "R9", what, count_o, c0);
    endtask

    task automatic t_edge_clear();
        write_reg(8'h03);
        edge_try(1'b1, 1'b0, "mode 00 rise");
        edge_try(1'b0, 1'b0, "mode 00 fall");
        write_reg(8'h0B);
        edge_try(1'b1, 1'b1, "mode 10 rise");
        edge_try(1'b0, 1'b0, "mode 10 fall");
        write_reg(8'h07);
        edge_try(1'b1, 1'b0, "mode 01 rise");
        edge_try(1'b0, 1'b1, "mode 01 fall");
        write_reg(8'h0F);
        edge_try(1'b1, 1'b1, "mode 11 rise");
        edge_try(1'b0, 1'b1, "mode 11 fall");
        interval_mode_i = 1'b1;
        edge_try(1'b1, 1'b0, "interval rise");
        edge_try(1'b0, 1'b0, "interval fall");
        interval_mode_i = 1'b0;
        write_reg(8'h03);
    endtask

    task automatic pulse_try(input logic newval, input bit exp_pulse, input string what);
        bit seen;
        @(negedge clk);
        cap_i = newval;
        if (exp_pulse) begin
            repeat (2) @(posedge clk);
            #1ns;
            chk(cap_irq_o == 1'b1, "R10", {what, " pulse"}, cap_irq_o, 1);
            @(posedge clk);
            #1ns;
            chk(cap_irq_o == 1'b0, "R10", {what, " pulse end"}, cap_irq_o, 0);
        end else begin
            seen = 1'b0;
            for (int i = 0; i < 4; i++) begin
                @(posedge clk); #1ns;
                if (cap_irq_o) seen = 1'b1;
            end
            chk(!seen, "R10", {what, " no pulse"}, seen, 0);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_cap_irq();
        write_reg(8'h13);
        pulse_try(1'b1, 1'b1, "rise pol1");
        pulse_try(1'b0, 1'b0, "fall pol1");
        write_reg(8'h03);
        pulse_try(1'b1, 1'b0, "rise pol0");
        pulse_try(1'b0, 1'b1, "fall pol0");
    endtask

    initial begin
        #(150000 * 4ns);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rates();
        t_sw_write();
        t_overflow_high();
        t_overflow_low();
        t_set_priority();
        t_edge_clear();
        t_cap_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule